// File: doc/BRIEF.md
# Address-Collision Busy Arbiter

This block sits beside a two-port memory and watches the address and active-low chip enable that each port presents. When both ports are enabled on the same word, it flags exactly one of them busy (active low): the port whose address or enable settled later. The port that was stable first carries on. Arrival order is resolved in clock cycles. A port's arrival time is the last cycle in which its address or its enable changed. When both ports change in the same cycle, the right port loses.

The arbiter runs in one of two modes. As a master it generates both busy flags on its outputs. As a slave it holds its busy outputs inactive and takes busy from two external inputs. In both modes it drives a write-inhibit flag for each port, which the memory uses to block a write. A master derives write inhibit from its own arbitration result and ignores the external pins. A slave derives it from the external pins. The asynchronous reset is released through a two-stage synchroniser, so the first arbitration edge is the third rising clock edge after release.

Top module: `colarb_busy`

## Requirements
- R1: While the two addresses differ, both busy outputs are high at the clock edge that follows.
- R2: While either chip enable is high (inactive), both busy outputs are high at the following edge, even when the addresses are equal.
- R3: When both ports are enabled on equal addresses, the edge that samples this drives low the busy output of the port whose address or enable changed more recently. The other busy output stays high.
- R4: Busy outputs are never low together.
- R5: If both ports change in the same cycle and match, the right busy output goes low and the left stays high.
- R6: While a match persists and neither port changes, the busy outputs hold their values. A port that leaves and re-enters the match becomes the later arrival, even if it had priority before.
- R7: Busy is released (high) at the first edge that samples the end of the match, whether the addresses diverge or an enable is withdrawn.
- R8: In master mode (slave_mode = 0), winh_l/winh_r are high exactly when the arbiter flags that port busy. The external busy inputs have no effect.
- R9: In slave mode (slave_mode = 1), both busy outputs are held high. winh_l equals the inverse of busy_l_in_n and winh_r the inverse of busy_r_in_n, combinationally.
- R10: Reset holds both busy outputs high, and for two edges after release, and clears arrival history. Ports found enabled at the first active edge count as arriving together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| addr_l | input | ADDR_W | Left port address |
| addr_r | input | ADDR_W | Right port address |
| ce_l_n | input | 1 | Left chip enable, active low |
| ce_r_n | input | 1 | Right chip enable, active low |
| slave_mode | input | 1 | 0 = master (generate busy), 1 = slave (accept busy) |
| busy_l_in_n | input | 1 | External left busy, active low, used in slave mode |
| busy_r_in_n | input | 1 | External right busy, active low, used in slave mode |
| busy_l_n | output | 1 | Left busy, active low |
| busy_r_n | output | 1 | Right busy, active low |
| winh_l | output | 1 | Left write inhibit, active high |
| winh_r | output | 1 | Right write inhibit, active high |

## Verification
The assertions check the following on every cycle:
- The two busy flags are mutually exclusive.
- No busy flag is raised without a sampled match, and a flag is released once the match ends.
- A one-sided change under a match flags the changing port, and a tie flags the right port.
- Busy holds steady while neither port changes.
- In slave mode the outputs stay quiet, and in master mode write inhibit tracks the busy output.

Only the bench's scenarios show the following:
- Ownership carries across a break and re-entry of the match.
- History is cleared by a reset in mid-run.
- The busy pins are ignored in master mode.
- Long random sequences agree with the timestamp-based reference.

// File: rtl/colarb_pkg.sv
package colarb_pkg;

  // Which port currently proceeds; the other one is flagged busy.
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } owner_e;

  localparam int unsigned NPORT = 2;
  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/colarb_rst_sync.sv
module colarb_rst_sync
  import colarb_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/colarb_port_track.sv
module colarb_port_track #(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          en_i,
  output logic          chg_o
);

  logic [AW-1:0] prev_addr_q;
  logic          prev_en_q;
  logic          upd_en;

  // A change of address or enable marks a fresh arrival for this port.
  always_comb begin
    chg_o  = (en_i != prev_en_q) || (addr_i != prev_addr_q);
    upd_en = chg_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr_q <= '0;
      prev_en_q   <= 1'b0;
    end else if (upd_en) begin
      prev_addr_q <= addr_i;
      prev_en_q   <= en_i;
    end
  end

  AST_ENABLE_IS_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_i) |-> chg_o); // R3

endmodule

// File: rtl/colarb_core.sv
module colarb_core
  import colarb_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_l,
  input  logic [AW-1:0] addr_r,
  input  logic          en_l,
  input  logic          en_r,
  input  logic          chg_l,
  input  logic          chg_r,
  output logic          busy_l_o,
  output logic          busy_r_o
);

  owner_e owner_q;
  owner_e owner_d;
  logic   match;
  logic   owner_en;

  assign match = en_l && en_r && (addr_l == addr_r);

  // Next owner: the port that did not change most recently proceeds.
  always_comb begin
    owner_d = owner_q;
    if (!match) begin
      owner_d = OWN_NONE;
    end else if (chg_l && !chg_r) begin
      owner_d = OWN_RIGHT;
    end else if (chg_r && !chg_l) begin
      owner_d = OWN_LEFT;
    end else if (chg_l && chg_r) begin
      owner_d = OWN_LEFT;              // tie: right is flagged
    end else if (owner_q == OWN_NONE) begin
      owner_d = OWN_LEFT;              // both already present at reset exit
    end
    owner_en = (owner_d != owner_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
    end else if (owner_en) begin
      owner_q <= owner_d;
    end
  end

  assign busy_l_o = (owner_q == OWN_RIGHT);
  assign busy_r_o = (owner_q == OWN_LEFT);

  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_l_o && busy_r_o)); // R4
  AST_DIFF_ADDR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_l != addr_r) |=> (!busy_l_o && !busy_r_o)); // R1
  AST_DISABLED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_l || !en_r) |=> (!busy_l_o && !busy_r_o)); // R2
  AST_MATCH_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (busy_l_o != busy_r_o)); // R3
  AST_LATE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (match && chg_l && !chg_r) |=> busy_l_o); // R3
  AST_LATE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (match && chg_r && !chg_l) |=> busy_r_o); // R3
  AST_TIE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (match && chg_l && chg_r) |=> (busy_r_o && !busy_l_o)); // R5
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !chg_l && !chg_r && (busy_l_o || busy_r_o))
      |=> ($stable(busy_l_o) && $stable(busy_r_o))); // R6

endmodule

// File: rtl/colarb_busy.sv
module colarb_busy
  import colarb_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              ce_l_n,
  input  logic              ce_r_n,
  input  logic              slave_mode,
  input  logic              busy_l_in_n,
  input  logic              busy_r_in_n,
  output logic              busy_l_n,
  output logic              busy_r_n,
  output logic              winh_l,
  output logic              winh_r
);

  localparam int unsigned LEFT  = 0;
  localparam int unsigned RIGHT = 1;

  logic              rst_n;
  logic [ADDR_W-1:0] addr_v [NPORT];
  logic              en_v   [NPORT];
  logic              chg_v  [NPORT];
  logic              int_busy_l;
  logic              int_busy_r;

  colarb_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  assign addr_v[LEFT]  = addr_l;
  assign addr_v[RIGHT] = addr_r;
  assign en_v[LEFT]    = ~ce_l_n;
  assign en_v[RIGHT]   = ~ce_r_n;

  for (genvar g = 0; g < NPORT; g++) begin : g_trk
    colarb_port_track #(.AW(ADDR_W)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_i (addr_v[g]),
      .en_i   (en_v[g]),
      .chg_o  (chg_v[g])
    );
  end

  colarb_core #(.AW(ADDR_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_l   (addr_v[LEFT]),
    .addr_r   (addr_v[RIGHT]),
    .en_l     (en_v[LEFT]),
    .en_r     (en_v[RIGHT]),
    .chg_l    (chg_v[LEFT]),
    .chg_r    (chg_v[RIGHT]),
    .busy_l_o (int_busy_l),
    .busy_r_o (int_busy_r)
  );

  // Mode selection: a master drives the pins and inhibits from its own
  // result; a slave keeps its pins quiet and inhibits from the pins.
  always_comb begin
    if (slave_mode) begin
      busy_l_n = 1'b1;
      busy_r_n = 1'b1;
      winh_l   = ~busy_l_in_n;
      winh_r   = ~busy_r_in_n;
    end else begin
      busy_l_n = ~int_busy_l;
      busy_r_n = ~int_busy_r;
      winh_l   = int_busy_l;
      winh_r   = int_busy_r;
    end
  end

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (busy_l_n && busy_r_n)); // R9
  AST_MASTER_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_mode |-> ((winh_l == !busy_l_n) && (winh_r == !busy_r_n))); // R8

endmodule

// File: tb/colarb_busy_tb.sv
module colarb_busy_tb;

  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic [AW-1:0] addr_l = '0;
  logic [AW-1:0] addr_r = '0;
  logic          ce_l_n = 1'b1;
  logic          ce_r_n = 1'b1;
  logic          slave_mode = 1'b0;
  logic          busy_l_in_n = 1'b1;
  logic          busy_r_in_n = 1'b1;
  logic          busy_l_n, busy_r_n, winh_l, winh_r;

  int    n_checks = 0;
  int    n_errors = 0;
  string req = "R10";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  colarb_busy #(.ADDR_W(AW)) u_dut (
    .clk(clk), .arst_n(arst_n), .addr_l(addr_l), .addr_r(addr_r),
    .ce_l_n(ce_l_n), .ce_r_n(ce_r_n), .slave_mode(slave_mode),
    .busy_l_in_n(busy_l_in_n), .busy_r_in_n(busy_r_in_n),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n), .winh_l(winh_l), .winh_r(winh_r)
  );

  // Reference model: timestamps of the last change on each port.
  int            cyc = 0;
  int            stamp_l = 0, stamp_r = 0;
  int            rel_cnt = 0;
  logic [AW-1:0] pa_l = '0, pa_r = '0;
  bit            pe_l = 0, pe_r = 0;
  bit            mb_l = 0, mb_r = 0;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n || rel_cnt < 2) begin
      if (arst_n) rel_cnt = rel_cnt + 1;
      else rel_cnt = 0;
      stamp_l = 0; stamp_r = 0; pa_l = '0; pa_r = '0;
      pe_l = 0; pe_r = 0; mb_l = 0; mb_r = 0;
    end else begin
      cyc = cyc + 1;
      if ((!ce_l_n) != pe_l || addr_l != pa_l) stamp_l = cyc;
      if ((!ce_r_n) != pe_r || addr_r != pa_r) stamp_r = cyc;
      pe_l = !ce_l_n; pe_r = !ce_r_n; pa_l = addr_l; pa_r = addr_r;
      if (pe_l && pe_r && pa_l == pa_r) begin
        if (stamp_l > stamp_r) begin mb_l = 1; mb_r = 0; end
        else begin mb_l = 0; mb_r = 1; end
      end else begin
        mb_l = 0; mb_r = 0;
      end
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("busy_l_n", busy_l_n, slave_mode ? 1'b1 : logic'(!mb_l));
      chk("busy_r_n", busy_r_n, slave_mode ? 1'b1 : logic'(!mb_r));
      chk("winh_l", winh_l, slave_mode ? logic'(!busy_l_in_n) : logic'(mb_l));
      chk("winh_r", winh_r, slave_mode ? logic'(!busy_r_in_n) : logic'(mb_r));
    end
  end

  task automatic drive(input int al, input int ar, input bit el, input bit er, input int n);
    addr_l = AW'(al); addr_r = AW'(ar); ce_l_n = !el; ce_r_n = !er;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #3;
    end
  endtask

  initial begin
    #20000000;
    n_errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    // R10: reset state
    req = "R10";
    drive(3, 3, 1, 1, 4);
    @(posedge clk); #3; arst_n = 1'b1;
    drive(3, 3, 1, 1, 4);          // held through reset -> tie, right busy
    req = "R1";
    drive(1, 2, 1, 1, 3);
    drive(100, 101, 1, 1, 2);
    req = "R2";
    drive(7, 7, 0, 1, 3);
    drive(7, 7, 1, 0, 3);
    req = "R3";
    drive(5, 6, 1, 0, 2);
    drive(5, 5, 1, 1, 4);          // right arrives later
    req = "R7";
    drive(5, 9, 1, 1, 2);          // addresses diverge
    req = "R3";
    drive(9, 9, 1, 1, 3);          // left arrives later
    req = "R7";
    drive(9, 9, 1, 0, 2);          // enable withdrawn
    req = "R5";
    drive(12, 12, 1, 1, 3);
    req = "R6";
    drive(12, 12, 0, 1, 1);
    drive(12, 12, 1, 1, 4);        // left re-enters later
    req = "R8";
    for (int i = 0; i < 16; i++) begin
      busy_l_in_n = i[0]; busy_r_in_n = i[1];
      drive(20, 20 + (i % 3 == 0 ? 0 : 1), 1, 1, 1);
    end
    req = "R9";
    slave_mode = 1'b1;
    for (int i = 0; i < 12; i++) begin
      busy_l_in_n = i[1]; busy_r_in_n = i[0];
      drive(30, 30, i[2], 1, 1);
    end
    slave_mode = 1'b0; busy_l_in_n = 1'b1; busy_r_in_n = 1'b1;
    req = "R10";
    drive(40, 40, 1, 1, 3);
    arst_n = 1'b0;
    drive(40, 40, 1, 1, 2);
    arst_n = 1'b1;
    drive(40, 40, 1, 1, 4);
    req = "R4";
    for (int i = 0; i < 400; i++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, 1);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule